// File: doc/BRIEF.md
# Scatter-gather to descriptor table builder

The block accepts a stream of scatter-gather segments, each a 32-bit bus address with a byte length, and turns them into a table of physical region descriptors for a bus-master disk DMA engine. Each descriptor occupies two 32-bit words. The first word is the base address. The second is a count word that carries the byte count and, in normal format, an end-of-table flag. Words leave one per handshake on a valid/ready port, and the address word always goes before its count word.

Segments are cut so that no descriptor spans a 64 KiB boundary. A whole 64 KiB chunk is emitted as two 32 KiB descriptors, so no count field is ever zero. A second, packed count format serves a different controller. The table has a fixed size limit. An input with no bytes in it is reported as an error. A start pulse, sampled together with the format select, begins a new table. After the table is complete, the block reports the number of descriptors it built and any error flags, and holds that state until the next start pulse.

Top module: `sg_prd_builder`

## Requirements
- R1: After reset or a start pulse, entry_count_o is 0, overflow_o, empty_o and done_o are low, seg_ready_o is high and word_valid_o is low. The format select is sampled only on the start pulse; after reset the normal format is in force.
- R2: A segment is emitted as consecutive chunks. Each chunk starts at the running address and ends at the next 64 KiB boundary or at the end of the segment, whichever comes first. The address word of each descriptor is the chunk's start address.
- R3: In normal format, bits 15:0 of the count word hold the chunk length and bits 30:16 are zero.
- R4: A chunk of exactly 64 KiB becomes two descriptors. The first has the chunk address and count 0x8000; the second has the chunk address plus 0x8000 and count 0x8000. Each one uses its own table entry.
- R5: In normal format, bit 31 of the count word is set on the final descriptor of a successful table and clear on all others.
- R6: Every descriptor is sent as its address word followed by its count word. While word_valid_o is high and word_ready_i is low, word_valid_o stays high and word_data_o does not change.
- R7: When one more descriptor is needed and MAX_ENTRIES descriptors have already been emitted, the pending count word is sent without the end bit. overflow_o then rises with entry_count_o equal to MAX_ENTRIES. Segments up to and including the one marked last are accepted and dropped, and done_o then rises.
- R8: If the last segment arrives and no descriptor has been produced, empty_o and done_o rise and entry_count_o stays 0.
- R9: In packed format, the count word is ((length >> 2) - 1) in bits 31:16 with bits 15:0 zero, and no end bit is set. Lengths and addresses are assumed to be multiples of 4.
- R10: When a table completes, done_o is high and entry_count_o equals the number of descriptors emitted, which is nonzero on success.
- R11: A zero-length segment adds no descriptor. A zero-length segment marked last still closes a non-empty table and sets the end bit on the held count word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new table; clears count and flags |
| packed_mode_i | input | 1 | Format select sampled on start_i (1 = packed count) |
| seg_valid_i | input | 1 | Segment valid |
| seg_ready_o | output | 1 | Segment accepted when high with seg_valid_i |
| seg_addr_i | input | 32 | Segment bus address |
| seg_len_i | input | LEN_W | Segment byte length |
| seg_last_i | input | 1 | Marks the final segment of the table |
| word_valid_o | output | 1 | Output word valid |
| word_ready_i | input | 1 | Output word taken when high with word_valid_o |
| word_data_o | output | 32 | Address or count word |
| entry_count_o | output | CNT_W | Descriptors emitted so far |
| overflow_o | output | 1 | Table limit exceeded |
| empty_o | output | 1 | Input produced no descriptor |
| done_o | output | 1 | Table finished; held until next start |

## Verification
A segment offered on a falling edge is taken on the next rising edge. Its first address word appears two rising edges later, once the chunk state has been loaded and the next descriptor has been chosen. A count word is released only after the following descriptor has been decided or the last segment has been seen, so it can lag its address word by several cycles. For these reasons the bench does not predict cycle positions. It gathers every word handshaken at falling edges under random backpressure and compares the whole stream against a model built from the requirements. It reads entry_count_o and the flags on the first falling edge at which done_o is high. It also checks, one falling edge after any stall, that the stalled word is unchanged.

// File: rtl/sg_prd_pkg.sv
package sg_prd_pkg;
  localparam int unsigned BOUND_W   = 16;
  localparam logic [15:0] HALF_SPAN = 16'h8000;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_CHUNK,
    ST_ADDR,
    ST_CNT,
    ST_DRAIN,
    ST_DONE
  } build_state_e;
endpackage

// File: rtl/sg_chunk_calc.sv
module sg_chunk_calc #(
  parameter int unsigned LEN_W = 32
) (
  input  logic [31:0]      addr_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic [15:0]      chunk_len_o
);
  import sg_prd_pkg::*;

  localparam logic [16:0] SPAN = 17'h10000;

  logic [16:0] to_bound;
  logic [16:0] raw_len;

  always_comb begin
    to_bound = SPAN - {1'b0, addr_i[BOUND_W-1:0]};
    if (rem_i >= LEN_W'(to_bound)) raw_len = to_bound;
    else                           raw_len = rem_i[16:0];
    // a full 64 KiB span is cut in half so the count never reads as zero
    chunk_len_o = (raw_len == SPAN) ? HALF_SPAN : raw_len[15:0];
  end

  // p_no_cross_r2
  always_comb begin
    if (rem_i != '0) begin
      assert ((chunk_len_o != 16'd0) &&
              (18'(addr_i[15:0]) + 18'(chunk_len_o) <= 18'h10000))
        else $error("p_no_cross_r2");
    end
  end
endmodule

// File: rtl/prd_cnt_fmt.sv
module prd_cnt_fmt (
  input  logic [15:0] len_i,
  input  logic        packed_i,
  input  logic        final_i,
  output logic [31:0] word_o
);
  logic [15:0] quads_m1;

  always_comb begin
    quads_m1 = {2'b00, len_i[15:2]} - 16'd1;
    if (packed_i) word_o = {quads_m1, 16'h0000};
    else          word_o = {final_i, 15'h0000, len_i};
  end
endmodule

// File: rtl/sg_prd_builder.sv
module sg_prd_builder #(
  parameter int unsigned LEN_W       = 32,
  parameter int unsigned MAX_ENTRIES = 16,
  localparam int unsigned CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             packed_mode_i,
  input  logic             seg_valid_i,
  output logic             seg_ready_o,
  input  logic [31:0]      seg_addr_i,
  input  logic [LEN_W-1:0] seg_len_i,
  input  logic             seg_last_i,
  output logic             word_valid_o,
  input  logic             word_ready_i,
  output logic [31:0]      word_data_o,
  output logic [CNT_W-1:0] entry_count_o,
  output logic             overflow_o,
  output logic             empty_o,
  output logic             done_o
);
  import sg_prd_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ENTRIES);

  build_state_e     state_q;
  logic [31:0]      cur_addr_q;
  logic [LEN_W-1:0] rem_q;
  logic             last_q;
  logic [15:0]      pend_len_q;
  logic             pend_vld_q;
  logic             fin_q;
  logic             mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             empty_q;

  logic [15:0]      chunk_len;
  logic [31:0]      cnt_word;
  logic             seg_fire;
  logic             word_fire;

  sg_chunk_calc #(.LEN_W(LEN_W)) u_chunk (
    .addr_i      (cur_addr_q),
    .rem_i       (rem_q),
    .chunk_len_o (chunk_len)
  );

  prd_cnt_fmt u_fmt (
    .len_i    (pend_len_q),
    .packed_i (mode_q),
    .final_i  (fin_q),
    .word_o   (cnt_word)
  );

  assign seg_ready_o   = (state_q == ST_FETCH) || (state_q == ST_DRAIN);
  assign word_valid_o  = (state_q == ST_ADDR) || (state_q == ST_CNT);
  assign word_data_o   = (state_q == ST_ADDR) ? cur_addr_q : cnt_word;
  assign seg_fire      = seg_valid_i && seg_ready_o;
  assign word_fire     = word_valid_o && word_ready_i;
  assign entry_count_o = cnt_q;
  assign overflow_o    = ovf_q;
  assign empty_o       = empty_q;
  assign done_o        = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_FETCH;
      cur_addr_q <= '0;
      rem_q      <= '0;
      last_q     <= 1'b0;
      pend_len_q <= '0;
      pend_vld_q <= 1'b0;
      fin_q      <= 1'b0;
      mode_q     <= 1'b0;
      cnt_q      <= '0;
      ovf_q      <= 1'b0;
      empty_q    <= 1'b0;
    end else if (start_i) begin
      state_q    <= ST_FETCH;
      rem_q      <= '0;
      last_q     <= 1'b0;
      pend_vld_q <= 1'b0;
      fin_q      <= 1'b0;
      mode_q     <= packed_mode_i;
      cnt_q      <= '0;
      ovf_q      <= 1'b0;
      empty_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_FETCH: if (seg_fire) begin
          if (seg_len_i == '0) begin
            if (seg_last_i) begin
              if (pend_vld_q) begin
                fin_q   <= 1'b1;
                state_q <= ST_CNT;
              end else begin
                empty_q <= 1'b1;
                state_q <= ST_DONE;
              end
            end
          end else begin
            cur_addr_q <= seg_addr_i;
            rem_q      <= seg_len_i;
            last_q     <= seg_last_i;
            state_q    <= ST_CHUNK;
          end
        end
        ST_CHUNK: begin
          if (pend_vld_q) begin
            // a further descriptor exists, so the held count is not final
            fin_q   <= 1'b0;
            state_q <= ST_CNT;
          end else if (cnt_q == CNT_MAX) begin
            ovf_q   <= 1'b1;
            state_q <= last_q ? ST_DONE : ST_DRAIN;
          end else begin
            state_q <= ST_ADDR;
          end
        end
        ST_ADDR: if (word_fire) begin
          pend_len_q <= chunk_len;
          pend_vld_q <= 1'b1;
          cnt_q      <= cnt_q + 1'b1;
          cur_addr_q <= cur_addr_q + 32'(chunk_len);
          rem_q      <= rem_q - LEN_W'(chunk_len);
          if (rem_q == LEN_W'(chunk_len)) begin
            if (last_q) begin
              fin_q   <= 1'b1;
              state_q <= ST_CNT;
            end else begin
              state_q <= ST_FETCH;
            end
          end else begin
            state_q <= ST_CHUNK;
          end
        end
        ST_CNT: if (word_fire) begin
          pend_vld_q <= 1'b0;
          state_q    <= fin_q ? ST_DONE : ST_CHUNK;
        end
        ST_DRAIN: if (seg_fire && seg_last_i) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_FETCH;
      endcase
    end
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !word_ready_i && !start_i) |=> (word_valid_o && $stable(word_data_o)))
    else $error("p_hold_r6");

  p_limit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_count_o <= CNT_MAX)
    else $error("p_limit_r7");

  p_ovf_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> (entry_count_o == CNT_MAX))
    else $error("p_ovf_full_r7");

  p_empty_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (entry_count_o == '0 && !word_valid_o))
    else $error("p_empty_zero_r8");

  p_start_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (entry_count_o == '0 && !overflow_o && !empty_o && !done_o))
    else $error("p_start_clear_r1");
endmodule

// File: tb/sg_prd_builder_tb.sv
module sg_prd_builder_tb;
  localparam int unsigned LEN_W = 32;
  localparam int unsigned MAXE  = 16;
  localparam int unsigned CNT_W = $clog2(MAXE + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic packed_mode_i = 1'b0;
  logic seg_valid_i = 1'b0;
  logic seg_ready_o;
  logic [31:0] seg_addr_i = '0;
  logic [LEN_W-1:0] seg_len_i = '0;
  logic seg_last_i = 1'b0;
  logic word_valid_o;
  logic word_ready_i = 1'b0;
  logic [31:0] word_data_o;
  logic [CNT_W-1:0] entry_count_o;
  logic overflow_o, empty_o, done_o;

  always #5 clk = ~clk;

  sg_prd_builder #(.LEN_W(LEN_W), .MAX_ENTRIES(MAXE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .packed_mode_i(packed_mode_i),
    .seg_valid_i(seg_valid_i), .seg_ready_o(seg_ready_o), .seg_addr_i(seg_addr_i),
    .seg_len_i(seg_len_i), .seg_last_i(seg_last_i), .word_valid_o(word_valid_o),
    .word_ready_i(word_ready_i), .word_data_o(word_data_o),
    .entry_count_o(entry_count_o), .overflow_o(overflow_o), .empty_o(empty_o),
    .done_o(done_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [31:0] seg_a [0:15];
  logic [31:0] seg_l [0:15];
  int nseg;
  bit mode;
  logic [31:0] exp_q[$];
  logic [31:0] got_q[$];
  int exp_cnt;
  bit exp_ovf, exp_empty;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cnt_word(logic [31:0] len, bit pk, bit fin);
    if (pk) return (((len >> 2) - 32'd1) & 32'hFFFF) << 16;
    return len | (fin ? 32'h8000_0000 : 32'h0);
  endfunction

  function automatic void build_expected();
    logic [31:0] a, r, cap, ch, pend;
    bit pv, stop;
    exp_q.delete();
    exp_cnt = 0; exp_ovf = 0; exp_empty = 0;
    pv = 0; stop = 0; pend = 0;
    for (int i = 0; i < nseg && !stop; i++) begin
      a = seg_a[i]; r = seg_l[i];
      while (r != 0 && !stop) begin
        cap = 32'h10000 - (a & 32'hFFFF);
        ch  = (cap < r) ? cap : r;
        if (ch == 32'h10000) ch = 32'h8000;
        if (pv) begin exp_q.push_back(cnt_word(pend, mode, 0)); pv = 0; end
        if (exp_cnt == MAXE) begin exp_ovf = 1; stop = 1; end
        else begin
          exp_q.push_back(a);
          pend = ch; pv = 1; exp_cnt++;
          a = a + ch; r = r - ch;
        end
      end
    end
    if (pv) exp_q.push_back(cnt_word(pend, mode, 1));
    if (exp_cnt == 0) exp_empty = 1;
  endfunction

  task automatic drive_segs();
    for (int i = 0; i < nseg; i++) begin
      seg_valid_i = 1'b1;
      seg_addr_i  = seg_a[i];
      seg_len_i   = seg_l[i];
      seg_last_i  = (i == nseg - 1);
      while (!seg_ready_o) @(negedge clk);
      @(negedge clk);
    end
    seg_valid_i = 1'b0;
    seg_last_i  = 1'b0;
  endtask

  task automatic collect(string req);
    bit stall = 0;
    logic [31:0] stall_w = '0;
    forever begin
      if (done_o) break;
      word_ready_i = ($urandom % 4) != 0;
      if (stall)
        check(word_valid_o && word_data_o == stall_w, "R6", "stalled word changed",
              word_data_o, stall_w);
      if (word_valid_o && word_ready_i) begin
        got_q.push_back(word_data_o);
        stall = 0;
      end else if (word_valid_o) begin
        stall = 1; stall_w = word_data_o;
      end else stall = 0;
      @(negedge clk);
    end
    word_ready_i = 1'b0;
  endtask

  task automatic run_table(string req);
    build_expected();
    @(negedge clk);
    start_i = 1'b1; packed_mode_i = mode;
    @(negedge clk);
    start_i = 1'b0;
    // R1 state after start
    check(entry_count_o == 0 && !done_o && !overflow_o && !empty_o && seg_ready_o,
          "R1", "clear after start", {entry_count_o, done_o, overflow_o, empty_o},
          32'd0);
    got_q.delete();
    fork
      drive_segs();
      collect(req);
    join
    check(got_q.size() == exp_q.size(), req, "word count",
          got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], req, $sformatf("word %0d", i), got_q[i], exp_q[i]);
    check(32'(entry_count_o) == exp_cnt, "R10", {req, " entry count"},
          32'(entry_count_o), exp_cnt);
    check(overflow_o == exp_ovf, "R7", {req, " overflow flag"}, overflow_o, exp_ovf);
    check(empty_o == exp_empty, "R8", {req, " empty flag"}, empty_o, exp_empty);
  endtask

  function automatic logic [31:0] rnd_len(bit pk);
    logic [31:0] l;
    case ($urandom % 6)
      0: l = 0;
      1: l = ($urandom % 32'h800) * 2 + 2;
      2: l = $urandom % 32'h18000 + 2;
      3: l = 32'h10000;
      4: l = 32'h20000 + ($urandom % 32'h100) * 4;
      default: l = $urandom % 32'h4000 + 4;
    endcase
    return pk ? (l & ~32'h3) : (l & ~32'h1);
  endfunction

  function automatic logic [31:0] rnd_addr();
    case ($urandom % 3)
      0: return $urandom & 32'hFFFF_0000;
      1: return ($urandom & 32'hFFFF_0000) | 32'hFFF0;
      default: return $urandom & ~32'h3;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(entry_count_o == 0 && !done_o && !overflow_o && !empty_o &&
          seg_ready_o && !word_valid_o, "R1", "reset state",
          {entry_count_o, done_o, overflow_o, empty_o, seg_ready_o, word_valid_o}, 32'h2);
    rst_ni = 1'b1;
    @(negedge clk);
    check(entry_count_o == 0 && !done_o && seg_ready_o, "R1", "after release",
          {entry_count_o, done_o, seg_ready_o}, 32'h1);

    // R3 R5 single short segment
    mode = 0; nseg = 1; seg_a[0] = 32'h0010_0100; seg_l[0] = 32'h200;
    run_table("R3");
    // R2 segment crossing a 64 KiB boundary
    nseg = 1; seg_a[0] = 32'h0003_FF00; seg_l[0] = 32'h300;
    run_table("R2");
    // R4 full aligned 64 KiB
    nseg = 1; seg_a[0] = 32'h0050_0000; seg_l[0] = 32'h10000;
    run_table("R4");
    // R4 R2 two spans plus tail, then a second segment
    nseg = 2; seg_a[0] = 32'h0020_0000; seg_l[0] = 32'h20010;
    seg_a[1] = 32'h0070_8000; seg_l[1] = 32'h9000;
    run_table("R4");
    // R11 zero-length segments, last one zero-length
    nseg = 4; seg_a[0] = 32'h1000; seg_l[0] = 0; seg_a[1] = 32'h2000; seg_l[1] = 32'h40;
    seg_a[2] = 32'h3000; seg_l[2] = 0; seg_a[3] = 32'h4000; seg_l[3] = 0;
    run_table("R11");
    // R8 nothing to emit
    nseg = 2; seg_a[0] = 32'h100; seg_l[0] = 0; seg_a[1] = 32'h200; seg_l[1] = 0;
    run_table("R8");
    // R7 overflow in a non-last segment, followed by drained segments
    nseg = 3; seg_a[0] = 32'h0100_0000; seg_l[0] = 32'h90000;
    seg_a[1] = 32'h4000; seg_l[1] = 32'h100; seg_a[2] = 32'h8000; seg_l[2] = 32'h10;
    run_table("R7");
    // R7 exactly full table is not an overflow
    nseg = 1; seg_a[0] = 32'h0200_0000; seg_l[0] = 32'h80000;
    run_table("R7");
    // R9 packed format
    mode = 1; nseg = 2; seg_a[0] = 32'h0030_FFF0; seg_l[0] = 32'h20;
    seg_a[1] = 32'h0040_0000; seg_l[1] = 32'h10000;
    run_table("R9");
    // R1 format returns to normal on next start
    mode = 0; nseg = 1; seg_a[0] = 32'h800; seg_l[0] = 32'h8;
    run_table("R1");

    for (int t = 0; t < 40; t++) begin
      mode = ($urandom % 3) == 0;
      nseg = 1 + ($urandom % 6);
      for (int i = 0; i < nseg; i++) begin
        seg_a[i] = rnd_addr();
        seg_l[i] = rnd_len(mode);
      end
      run_table(mode ? "R9" : "R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule